// File: doc/BRIEF.md
# Decimated-Rate Droop Compensation FIR

This block is a compensation filter that follows a decimate-by-256 CIC stage. It flattens the passband sag that the CIC leaves behind. It runs on the fast processing clock. One decimated sample arrives per 256 fast cycles, so each output period lasts exactly 256 clocks. The filter stores the arriving sample in a 256-entry circular sample memory. It then uses one shared multiply-accumulate path to form a 255-tap convolution against a loadable coefficient table. The sample memory is read newest-first while the coefficient table is read from entry 0 upward.

A free-running 8-bit phase counter sequences each period. At phase 0 the held input sample is stored and the write pointer moves on. Phases 1 to 255 each issue one tap. The finished sum is sliced down to a 30-bit signed word. The block also outputs an offset-binary copy of that word, which a carry-output accumulator acting as a 1-bit density modulator can take directly. The sequencer runs only while the run enable (normally a clock-lock indication) is high.

Top module: `dfir_top`

## Requirements
- R1: During and right after reset, `out_vld` is 0, `out_word` is 0 and `out_ubin` is 30'h1FFF_FFFF.
- R2: While `run_en` stays high, `out_vld` pulses high for exactly one clock once in every 256 clocks, with exactly 256 clocks between pulses. There is one pulse per stored sample, except for a sample stored in a period that `run_en` cuts short.
- R3: `out_word` equals bits [45:16] of the exact signed sum over k = 0..254 of x(k)·h(k), taken modulo 2^30. x(k) is the 27-bit signed sample (26 fractional bits) written k stores before the most recent store. h(k) is the 20-bit signed coefficient (19 fractional bits) at table address k.
- R4: `out_ubin` always equals `out_word` + 30'h1FFF_FFFF, modulo 2^30.
- R5: `smp_in` is captured into a holding register on every clock where `smp_vld` is high. The value held at the phase-0 edge is the one stored, so a later strobe in the same period replaces an earlier one.
- R6: While `run_en` is low, no `out_vld` pulse occurs and the phase counter and write pointer stay at 0. The first clock edge with `run_en` high is a phase-0 edge that stores the held sample at memory address 0. Older memory contents are kept across the pause and take part in later sums.
- R7: The sample is stored at the clock edge that ends phase 0. `out_vld` for that sample rises 258 clock edges later, which is phase 3 of the following period.
- R8: A clock with `coef_we` high writes `coef_wdata` into table address `coef_addr`. Addresses 0..254 are used by later convolutions. Address 255 always reads as zero, and writes to it are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| run_en | input | 1 | Sequencer enable (clock-lock indication) |
| smp_vld | input | 1 | Strobe that captures `smp_in` |
| smp_in | input | 27 | Decimated input sample, signed, 26 fractional bits |
| coef_we | input | 1 | Coefficient table write enable |
| coef_addr | input | 8 | Coefficient table write address |
| coef_wdata | input | 20 | Coefficient value, signed, 19 fractional bits |
| out_word | output | 30 | Filter result, signed |
| out_ubin | output | 30 | Filter result in offset-binary form |
| out_vld | output | 1 | One-clock pulse when `out_word` updates |

## Verification
The hardest case to reach is a convolution that spans a pause of `run_en`. In that case the write pointer has restarted at address 0, the newest taps come from fresh samples, and the older taps reach back into memory written before the pause under a different pointer phase. The stimulus first fills the whole history with random samples. It then stops the sequencer right after a result emerges, loads a second coefficient set with full-scale alternating values, and strobes a new sample while idle. Finally it restarts and compares every result against a reference that tracks memory by address. The full-scale set drives the sum far past 30 bits, so the modulo slicing is also exercised.

// File: rtl/dfir_pkg.sv
package dfir_pkg;
  parameter int SMP_W   = 27;  // sample width, 26 fractional bits
  parameter int COEF_W  = 20;  // coefficient width, 19 fractional bits
  parameter int DEPTH   = 256; // history depth = decimation period
  parameter int OUT_W   = 30;
  parameter int OUT_LSB = 16;  // accumulator bit that lands in out_word[0]

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int NTAP   = DEPTH - 1;
  localparam int PROD_W = SMP_W + COEF_W;
  localparam int ACC_W  = PROD_W + ADDR_W;
  localparam logic [OUT_W-1:0] UBIN_OFS = {1'b0, {(OUT_W-1){1'b1}}};
endpackage

// File: rtl/dfir_seq.sv
module dfir_seq
  import dfir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  output logic [ADDR_W-1:0] phase,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic              wr_go,
  output logic              tap_go,
  output logic              tap_first,
  output logic              tap_last,
  output logic [ADDR_W-1:0] smp_raddr,
  output logic [ADDR_W-1:0] coef_raddr
);
  localparam logic [ADDR_W-1:0] A_ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(NTAP);

  logic [ADDR_W-1:0] phase_q, phase_d;
  logic [ADDR_W-1:0] wptr_q, wptr_d;

  always_comb begin
    phase_d = '0;
    wptr_d  = '0;
    if (run_en) begin
      phase_d = phase_q + A_ONE;
      wptr_d  = (phase_q == '0) ? (wptr_q + A_ONE) : wptr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      wptr_q  <= '0;
    end else begin
      phase_q <= phase_d;
      wptr_q  <= wptr_d;
    end
  end

  // tap k = phase-1: sample walks backwards from newest, coefficient walks forwards
  assign phase      = phase_q;
  assign wr_ptr     = wptr_q;
  assign wr_go      = run_en && (phase_q == '0);
  assign tap_go     = run_en && (phase_q != '0);
  assign tap_first  = (phase_q == A_ONE);
  assign tap_last   = (phase_q == A_LAST);
  assign smp_raddr  = wptr_q - phase_q;
  assign coef_raddr = phase_q - A_ONE;

  AST_IDLE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (phase_q == '0 && wptr_q == '0)); // R6
endmodule

// File: rtl/dfir_smp_mem.sv
module dfir_smp_mem
  import dfir_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_vld,
  input  logic signed [SMP_W-1:0]  smp_in,
  input  logic                     wr_go,
  input  logic [ADDR_W-1:0]        wr_ptr,
  input  logic                     rd_go,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic signed [SMP_W-1:0]  rd_data
);
  logic signed [SMP_W-1:0] hold_q;
  logic signed [SMP_W-1:0] rd_q;
  logic signed [SMP_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (smp_vld) begin
      hold_q <= smp_in;
    end
  end

  // storage array: no reset, one port used for either write (phase 0) or read
  always_ff @(posedge clk) begin
    if (wr_go) begin
      mem[wr_ptr] <= hold_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_go) begin
      rd_q <= mem[rd_addr];
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/dfir_coef_tab.sv
module dfir_coef_tab
  import dfir_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic signed [COEF_W-1:0]  wdata,
  input  logic                      rd_go,
  input  logic [ADDR_W-1:0]         raddr,
  output logic signed [COEF_W-1:0]  rd_data
);
  logic signed [COEF_W-1:0] tab [DEPTH];
  logic signed [COEF_W-1:0] rd_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i == DEPTH - 1) begin : g_zero
      assign tab[i] = '0;  // unused tap position is tied off
    end else begin : g_reg
      logic signed [COEF_W-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ent_q <= '0;
        end else if (we && (waddr == ADDR_W'(i))) begin
          ent_q <= wdata;
        end
      end
      assign tab[i] = ent_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_go) begin
      rd_q <= tab[raddr];
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/dfir_mac.sv
module dfir_mac
  import dfir_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run_en,
  input  logic                      tap_go,
  input  logic                      tap_first,
  input  logic                      tap_last,
  input  logic signed [SMP_W-1:0]   x_in,
  input  logic signed [COEF_W-1:0]  h_in,
  output logic signed [OUT_W-1:0]   out_word,
  output logic                      out_vld
);
  // stage 1: operands registered by the memories; stage 2: product; stage 3: sum
  logic v1_q, f1_q, l1_q;
  logic v2_q, f2_q, l2_q;
  logic dn_q, vld_q;
  logic signed [PROD_W-1:0] prod_q, prod_d;
  logic signed [ACC_W-1:0]  acc_q, acc_d;
  logic signed [OUT_W-1:0]  word_q, word_d;

  always_comb begin
    prod_d = prod_q;
    if (v1_q) begin
      prod_d = PROD_W'(x_in) * PROD_W'(h_in);
    end
    acc_d = acc_q;
    if (v2_q) begin
      acc_d = f2_q ? ACC_W'(prod_q) : (acc_q + ACC_W'(prod_q));
    end
    word_d = word_q;
    if (dn_q) begin
      word_d = acc_q[OUT_LSB +: OUT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q   <= 1'b0;
      f1_q   <= 1'b0;
      l1_q   <= 1'b0;
      v2_q   <= 1'b0;
      f2_q   <= 1'b0;
      l2_q   <= 1'b0;
      dn_q   <= 1'b0;
      vld_q  <= 1'b0;
      prod_q <= '0;
      acc_q  <= '0;
      word_q <= '0;
    end else begin
      v1_q   <= run_en && tap_go;
      f1_q   <= tap_first;
      l1_q   <= tap_last;
      v2_q   <= run_en && v1_q;
      f2_q   <= f1_q;
      l2_q   <= l1_q;
      dn_q   <= run_en && v2_q && l2_q;
      vld_q  <= run_en && dn_q;
      prod_q <= prod_d;
      acc_q  <= acc_d;
      word_q <= word_d;
    end
  end

  assign out_word = word_q;
  assign out_vld  = vld_q;

  AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld); // R2
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> $stable(out_word)); // R3
  AST_NO_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !out_vld); // R6
endmodule

// File: rtl/dfir_top.sv
module dfir_top
  import dfir_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run_en,
  input  logic                      smp_vld,
  input  logic signed [SMP_W-1:0]   smp_in,
  input  logic                      coef_we,
  input  logic [ADDR_W-1:0]         coef_addr,
  input  logic signed [COEF_W-1:0]  coef_wdata,
  output logic signed [OUT_W-1:0]   out_word,
  output logic [OUT_W-1:0]          out_ubin,
  output logic                      out_vld
);
  logic [ADDR_W-1:0]        phase, wr_ptr, smp_raddr, coef_raddr;
  logic                     wr_go, tap_go, tap_first, tap_last;
  logic signed [SMP_W-1:0]  x_rd;
  logic signed [COEF_W-1:0] h_rd;

  dfir_seq u_seq (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .phase(phase), .wr_ptr(wr_ptr), .wr_go(wr_go),
    .tap_go(tap_go), .tap_first(tap_first), .tap_last(tap_last),
    .smp_raddr(smp_raddr), .coef_raddr(coef_raddr)
  );

  dfir_smp_mem u_smp (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_in(smp_in),
    .wr_go(wr_go), .wr_ptr(wr_ptr), .rd_go(tap_go), .rd_addr(smp_raddr),
    .rd_data(x_rd)
  );

  dfir_coef_tab u_coef (
    .clk(clk), .rst_n(rst_n), .we(coef_we), .waddr(coef_addr),
    .wdata(coef_wdata), .rd_go(tap_go), .raddr(coef_raddr), .rd_data(h_rd)
  );

  dfir_mac u_mac (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tap_go(tap_go),
    .tap_first(tap_first), .tap_last(tap_last), .x_in(x_rd), .h_in(h_rd),
    .out_word(out_word), .out_vld(out_vld)
  );

  assign out_ubin = out_word + UBIN_OFS;

  AST_VLD_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (phase == ADDR_W'(3))); // R7
endmodule

// File: tb/tb_dfir_top.sv
module tb_dfir_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic smp_vld = 1'b0;
  logic signed [26:0] smp_in = '0;
  logic coef_we = 1'b0;
  logic [7:0] coef_addr = '0;
  logic signed [19:0] coef_wdata = '0;
  logic signed [29:0] out_word;
  logic [29:0] out_ubin;
  logic out_vld;

  always #4 clk = ~clk;

  dfir_top dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .smp_vld(smp_vld), .smp_in(smp_in),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
    .out_word(out_word), .out_ubin(out_ubin), .out_vld(out_vld)
  );

  typedef struct packed {
    logic        chk;
    logic        dbl;
    logic [29:0] word;
    logic [31:0] cyc;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  logic signed [26:0] mem_m [256];
  bit kn [256];
  logic signed [19:0] hm [256];
  logic signed [26:0] hold_m = '0;
  int wp = 0;
  logic [31:0] seed = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // scoreboard monitor
  int prev_cyc = 0;
  bit have_prev = 0;
  bit last_vld = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_vld) begin
        check(!last_vld, "R2 pulse width", 64'(last_vld), 64'd0);
        if (have_prev) check(cyc - prev_cyc == 256, "R2 spacing", 64'(cyc - prev_cyc), 64'd256);
        prev_cyc = cyc;
        have_prev = 1;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 spurious pulse", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(cyc == int'(e.cyc), "R7 latency", 64'(cyc), 64'(e.cyc));
          if (e.chk) begin
            check(out_word == e.word, e.dbl ? "R5 last strobe wins" : "R3 convolution",
                  64'(out_word), 64'(e.word));
            check(out_ubin == e.word + 30'h1FFF_FFFF, "R4 offset copy",
                  64'(out_ubin), 64'(e.word + 30'h1FFF_FFFF));
          end
        end
      end
      last_vld = out_vld;
      if (!run_en) have_prev = 0;
    end
  end

  task automatic load_coefs(input bit extreme);
    for (int a = 0; a < 256; a++) begin
      logic signed [19:0] v;
      if (extreme) v = a[0] ? 20'sh7FFFF : 20'sh80000;
      else v = 20'(rnd() >> 7);
      coef_we = 1'b1; coef_addr = 8'(a); coef_wdata = v;
      if (a < 255) hm[a] = v;  // R8: top entry stays zero
      @(negedge clk);
    end
    coef_we = 1'b0;
  endtask

  // called at the negedge before a phase-0 edge
  task automatic run_period(input logic signed [26:0] v, input bit dbl, input bit push, input bit stop);
    exp_t e;
    longint sum = 0;
    logic [63:0] su;
    bit known = 1;
    mem_m[wp] = hold_m;
    kn[wp] = 1;
    wp = (wp + 1) % 256;
    for (int k = 0; k < 255; k++) begin
      int a;
      a = (wp - 1 - k + 512) % 256;
      if (!kn[a]) known = 0;
      sum += longint'(mem_m[a]) * longint'(hm[k]);
    end
    su = sum;
    e.chk = known; e.dbl = dbl; e.word = su[45:16]; e.cyc = 32'(cyc + 1 + 258);
    if (push) exp_q.push_back(e);
    @(negedge clk);
    for (int i = 1; i <= 255; i++) begin
      if (i == 20) begin smp_vld = 1'b1; smp_in = dbl ? ~v : v; end
      if (i == 21) begin
        if (dbl) smp_in = v; else smp_vld = 1'b0;
      end
      if (i == 22) smp_vld = 1'b0;
      if (stop && i == 10) begin
        run_en = 1'b0;
        wp = 0;
        @(negedge clk);
        return;
      end
      @(negedge clk);
    end
    hold_m = v;
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin kn[a] = 0; hm[a] = '0; mem_m[a] = '0; end
    repeat (3) @(negedge clk);
    check(out_vld == 1'b0, "R1 vld in reset", 64'(out_vld), 64'd0);
    check(out_word == '0, "R1 word in reset", 64'(out_word), 64'd0);
    check(out_ubin == 30'h1FFF_FFFF, "R1 ubin in reset", 64'(out_ubin), 64'h1FFF_FFFF);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_vld == 1'b0 && out_word == '0, "R1 after release", 64'(out_word), 64'd0);
    load_coefs(0);  // R8
    run_en = 1'b1;
    for (int p = 0; p < 265; p++) run_period(27'(rnd() >> 5), (p % 7) == 3, 1, 0);
    run_period(27'(rnd() >> 5), 0, 0, 1);

    // idle: no pulses, reload coefficients, strobe a sample (R6)
    begin
      bit quiet = 1;
      for (int i = 0; i < 40; i++) begin
        if (out_vld) quiet = 0;
        @(negedge clk);
      end
      load_coefs(1);
      smp_vld = 1'b1; smp_in = 27'sh2345678; hold_m = 27'sh2345678;
      @(negedge clk);
      smp_vld = 1'b0;
      for (int i = 0; i < 40; i++) begin
        if (out_vld) quiet = 0;
        @(negedge clk);
      end
      check(quiet, "R6 no pulse while idle", 64'(!quiet), 64'd0);
      check(exp_q.size() == 0, "R2 all results before pause", 64'(exp_q.size()), 64'd0);
    end

    run_en = 1'b1;  // R6: first write lands at address 0 (wp model reset)
    for (int p = 0; p < 260; p++) begin
      logic signed [26:0] v;
      if (p % 5 == 4) v = 27'(rnd() >> 5);
      else v = p[0] ? 27'sh3FFFFFF : 27'sh4000000;
      run_period(v, 0, 1, 0);
    end
    run_period(27'sd0, 0, 0, 1);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R2 all results produced", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule